// File: doc/BRIEF.md
# Parallel Panel Frame Write Sequencer

This block pushes one frame of pixel words over an 8080-style parallel write bus to a display panel that keeps its own frame memory. Software selects trigger mode and sets a trigger bit. The block then drives chip select low and emits one write strobe for each pixel word it takes from a valid/ready stream. After the programmed number of words it releases chip select, pulses a done output and sets a sticky interrupt flag.

A 20-bit configuration word sets the shape of each strobe. It holds four phase lengths, measured in clock cycles, and an interface enable bit. The configuration word and the frame length are captured when a trigger is accepted and hold for the whole frame. While a frame is in flight, further trigger requests are dropped, because a second trigger can reset the panel. When the pixel stream has no word ready, the sequence waits with the write strobe held high.

Top module: `pbus_frame_writer`

## Requirements
- R1: After reset, cs_n and wr_n are 1, busy, frame_done and irq_flag are 0, and pix_ready is 0.
- R2: A trigger is accepted only when cfg_word[0]=1, trig_mode=1, trig_set=1, busy=0 and frame_words is nonzero. busy rises and cs_n falls at the following clock edge. Any other trigger has no effect. rs equals the inverse of cs_n.
- R3: cfg_word[19:16] is the chip-select setup length S and cfg_word[15:12] is the write setup length U. With data always available, cs_n is low and wr_n is high for exactly S+1+U cycles before the first wr_n fall. A length of 0 skips that phase.
- R4: cfg_word[11:8] is the write active length A. Every wr_n low pulse lasts max(A,1) cycles, and wr_n is low only while cs_n is low.
- R5: cfg_word[7:4] is the hold length H. With data always available, wr_n stays high for H+1+U cycles between strobes. cs_n rises exactly H cycles after the last wr_n rise.
- R6: A word is taken on a cycle with pix_valid and pix_ready both high. db presents the taken words in order and stays stable from the write setup phase through the hold phase.
- R7: pix_ready is high only between strobes while cs_n is low. A cycle with pix_ready high and pix_valid low is followed by a cycle with wr_n high.
- R8: A frame makes exactly frame_words strobes. With no stalls, busy stays high for S + N·(1+U+max(A,1)+H) cycles.
- R9: trig_set pulses while busy do not restart the frame, do not change the strobe count or the busy length, and do not start a new frame afterwards.
- R10: In the first cycle after busy falls, frame_done is 1 for exactly one cycle and irq_flag is 1. irq_flag stays set until irq_clr=1. If irq_clr coincides with completion, the set takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 20 | Phase lengths and interface enable |
| trig_mode | input | 1 | Trigger mode selected |
| trig_set | input | 1 | Software trigger request |
| irq_clr | input | 1 | Write-1 clear for irq_flag |
| frame_words | input | LEN_W | Pixel words per frame |
| pix_data | input | DW | Pixel word |
| pix_valid | input | 1 | Pixel word available |
| pix_ready | output | 1 | Block takes a word this cycle |
| cs_n | output | 1 | Panel chip select, active low |
| wr_n | output | 1 | Write strobe, active low |
| rs | output | 1 | Register/data select, high for pixel data |
| db | output | DW | Panel data bus |
| busy | output | 1 | Frame in flight |
| frame_done | output | 1 | One-cycle completion pulse |
| irq_flag | output | 1 | Sticky completion flag |

## Verification
Completion and a software clear of the interrupt flag can land in the same cycle. The bench provokes this by holding irq_clr high for a whole frame. It then checks that the flag reads 1 in the first idle cycle and stays set once the clear is released. A trigger request can also arrive while the current frame is still streaming. The bench pulses trig_set in the middle of a frame and judges the result by the strobe count, the busy length and a quiet bus afterwards.

// File: rtl/pbus_frame_writer.sv
module pbus_frame_writer #(
  parameter int DW    = 16,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [19:0]      cfg_word,
  input  logic             trig_mode,
  input  logic             trig_set,
  input  logic             irq_clr,
  input  logic [LEN_W-1:0] frame_words,
  input  logic [DW-1:0]    pix_data,
  input  logic             pix_valid,
  output logic             pix_ready,
  output logic             cs_n,
  output logic             wr_n,
  output logic             rs,
  output logic [DW-1:0]    db,
  output logic             busy,
  output logic             frame_done,
  output logic             irq_flag
);
  typedef enum logic [2:0] {S_IDLE, S_CSS, S_FETCH, S_WSU, S_ACT, S_HLD} st_t;

  st_t              st;
  logic [3:0]       tmr, css_l, wsu_l, act_l, hld_l;
  logic [LEN_W-1:0] left;
  logic [DW-1:0]    db_q;

  wire        unused_cfg = ^cfg_word[3:1];
  wire [3:0]  act_eff    = (cfg_word[11:8] == 4'd0) ? 4'd1 : cfg_word[11:8];
  wire        start      = cfg_word[0] && trig_mode && trig_set &&
                           (st == S_IDLE) && (frame_words != '0);
  wire        wend       = (st == S_ACT && tmr == 4'd0 && hld_l == 4'd0) ||
                           (st == S_HLD && tmr == 4'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      tmr <= '0;
      css_l <= '0; wsu_l <= '0; act_l <= 4'd1; hld_l <= '0;
      left <= '0;
      db_q <= '0;
      frame_done <= 1'b0;
      irq_flag <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (irq_clr) irq_flag <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          css_l <= cfg_word[19:16];
          wsu_l <= cfg_word[15:12];
          act_l <= act_eff;
          hld_l <= cfg_word[7:4];
          left  <= frame_words;
          if (cfg_word[19:16] != 4'd0) begin
            st  <= S_CSS;
            tmr <= cfg_word[19:16] - 4'd1;
          end else st <= S_FETCH;
        end
        S_CSS: if (tmr == 4'd0) st <= S_FETCH; else tmr <= tmr - 4'd1;
        S_FETCH: if (pix_valid) begin
          db_q <= pix_data;
          left <= left - 1'b1;
          if (wsu_l != 4'd0) begin
            st  <= S_WSU;
            tmr <= wsu_l - 4'd1;
          end else begin
            st  <= S_ACT;
            tmr <= act_l - 4'd1;
          end
        end
        S_WSU: if (tmr == 4'd0) begin
          st  <= S_ACT;
          tmr <= act_l - 4'd1;
        end else tmr <= tmr - 4'd1;
        S_ACT: if (tmr == 4'd0) begin
          if (hld_l != 4'd0) begin
            st  <= S_HLD;
            tmr <= hld_l - 4'd1;
          end
        end else tmr <= tmr - 4'd1;
        S_HLD: if (tmr != 4'd0) tmr <= tmr - 4'd1;
        default: st <= S_IDLE;
      endcase
      if (wend) begin
        if (left == '0) begin
          st <= S_IDLE;
          frame_done <= 1'b1;
          irq_flag <= 1'b1;
        end else st <= S_FETCH;
      end
    end
  end

  assign busy      = (st != S_IDLE);
  assign cs_n      = !busy;
  assign rs        = busy;
  assign wr_n      = (st != S_ACT);
  assign pix_ready = (st == S_FETCH);
  assign db        = db_q;

  // R4
  wr_low_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> !cs_n);
  // R6
  db_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && $past(!wr_n)) |-> $stable(db));
  // R7
  ready_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> (!cs_n && wr_n));
  // R9
  retrig_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && trig_set && !(pix_valid && pix_ready)) |=> $stable(left));
  // R10
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (irq_flag && !busy && $past(busy)));
endmodule

// File: tb/pbus_frame_writer_test.sv
module pbus_frame_writer_test;
  localparam int DW = 16, LEN_W = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [19:0] cfg_word = '0;
  logic trig_mode = 1'b0, trig_set = 1'b0, irq_clr = 1'b0;
  logic [LEN_W-1:0] frame_words = '0;
  logic [DW-1:0] pix_data = '0;
  logic pix_valid = 1'b0;
  logic pix_ready, cs_n, wr_n, rs, busy, frame_done, irq_flag;
  logic [DW-1:0] db;

  always #2 clk = ~clk;

  pbus_frame_writer #(.DW(DW), .LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .trig_mode(trig_mode),
    .trig_set(trig_set), .irq_clr(irq_clr), .frame_words(frame_words),
    .pix_data(pix_data), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .cs_n(cs_n), .wr_n(wr_n), .rs(rs), .db(db), .busy(busy),
    .frame_done(frame_done), .irq_flag(irq_flag));

  int checks = 0, errors = 0;
  logic [DW-1:0] sb[$];
  int e_css, e_wsu, e_act, e_hld, e_n, e_busy;
  bit gap_chk = 0;
  bit prev_wr = 1, prev_cs = 1, prev_rdy_idle = 0, first = 0;
  int low_w = 0, gap = 0, strobes = 0, busy_cnt = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (prev_cs && !cs_n) begin gap = 0; first = 1; strobes = 0; busy_cnt = 0; end
    if (!prev_wr && wr_n) begin
      chk(low_w == e_act, "R4 strobe width", low_w, e_act);
      low_w = 0; gap = 0;
    end
    if (prev_rdy_idle) chk(wr_n == 1'b1, "R7 stall keeps wr_n high", wr_n, 1);
    if (busy) busy_cnt++;
    if (!cs_n && wr_n) gap++;
    if (!wr_n) low_w++;
    if (rs !== !cs_n) chk(0, "R2 rs follows chip select", rs, !cs_n);
    if (prev_wr && !wr_n) begin
      strobes++;
      if (sb.size() == 0) chk(0, "R8 extra strobe", strobes, e_n);
      else begin
        logic [DW-1:0] ex;
        ex = sb.pop_front();
        chk(db == ex, "R6 data order", db, ex);
      end
      if (gap_chk) begin
        if (first) chk(gap == e_css + 1 + e_wsu, "R3 lead-in", gap, e_css + 1 + e_wsu);
        else       chk(gap == e_hld + 1 + e_wsu, "R5 word gap", gap, e_hld + 1 + e_wsu);
      end
      first = 0; gap = 0;
    end
    if (!prev_cs && cs_n) begin
      chk(strobes == e_n, "R8 strobe count", strobes, e_n);
      chk(sb.size() == 0, "R8 words left over", sb.size(), 0);
      chk(frame_done == 1'b1, "R10 done pulse", frame_done, 1);
      chk(irq_flag == 1'b1, "R10 flag set", irq_flag, 1);
      if (gap_chk) begin
        chk(gap == e_hld, "R5 tail hold", gap, e_hld);
        chk(busy_cnt == e_busy, "R8 busy length", busy_cnt, e_busy);
      end
    end
    prev_rdy_idle = pix_ready && !pix_valid;
    prev_wr = wr_n;
    prev_cs = cs_n;
  end

  task automatic send_words(input int n, input bit stall);
    int idx = 0, cyc = 0;
    bit take = 0;
    while (idx < n) begin
      @(negedge clk);
      if (take) begin idx++; take = 0; end
      cyc++;
      if (idx < n) begin
        pix_valid = stall ? (cyc % 3 != 1) : 1'b1;
        pix_data  = DW'(16'h1000 + idx * 16'h0123 + n);
        take = pix_valid && pix_ready;
      end else pix_valid = 1'b0;
    end
  endtask

  task automatic run_frame(input int s, input int u, input int a, input int h,
                           input int n, input bit stall, input bit retrig);
    e_css = s; e_wsu = u; e_hld = h; e_n = n;
    e_act = (a == 0) ? 1 : a;
    e_busy = s + n * (1 + u + e_act + h);
    gap_chk = !stall;
    for (int i = 0; i < n; i++) sb.push_back(DW'(16'h1000 + i * 16'h0123 + n));
    cfg_word = {4'(s), 4'(u), 4'(a), 4'(h), 4'b0001};
    frame_words = LEN_W'(n);
    trig_mode = 1'b1;
    fork
      send_words(n, stall);
      begin
        @(negedge clk) trig_set = 1'b1;
        @(negedge clk) trig_set = 1'b0;
        if (retrig) begin
          repeat (5) @(negedge clk);
          trig_set = 1'b1;
          @(negedge clk) trig_set = 1'b0;
        end
      end
    join
    while (busy) @(negedge clk);
  endtask

  task automatic clear_flag();
    @(negedge clk) irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;
    chk(irq_flag == 1'b0, "R10 flag cleared", irq_flag, 0);
  endtask

  task automatic try_bad_trigger(input logic [19:0] c, input logic m, input int n, input string req);
    cfg_word = c; trig_mode = m; frame_words = LEN_W'(n);
    @(negedge clk) trig_set = 1'b1;
    @(negedge clk) trig_set = 1'b0;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && cs_n == 1'b1 && wr_n == 1'b1, req, busy, 0);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1 && wr_n == 1 && busy == 0 && frame_done == 0 && irq_flag == 0 && pix_ready == 0,
        "R1 reset state", {cs_n, wr_n, busy, frame_done, irq_flag, pix_ready}, 6'b110000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 1 && busy == 0, "R1 after release", busy, 0);

    try_bad_trigger({4'd1, 4'd1, 4'd1, 4'd1, 4'b0000}, 1'b1, 3, "R2 enable bit clear");
    try_bad_trigger({4'd1, 4'd1, 4'd1, 4'd1, 4'b0001}, 1'b0, 3, "R2 trigger mode off");
    try_bad_trigger({4'd1, 4'd1, 4'd1, 4'd1, 4'b0001}, 1'b1, 0, "R2 zero-length frame");

    run_frame(2, 1, 3, 2, 4, 0, 0);
    @(negedge clk);
    chk(frame_done == 1'b0, "R10 done lasts one cycle", frame_done, 0);
    chk(irq_flag == 1'b1, "R10 flag sticky", irq_flag, 1);
    clear_flag();

    run_frame(0, 0, 0, 0, 5, 0, 0);
    clear_flag();

    run_frame(3, 2, 1, 0, 3, 0, 0);
    clear_flag();

    run_frame(1, 0, 2, 1, 4, 1, 0);
    clear_flag();

    run_frame(1, 1, 2, 1, 6, 0, 1);
    repeat (20) @(negedge clk);
    chk(busy == 1'b0 && cs_n == 1'b1, "R9 no frame after retrigger", busy, 0);
    clear_flag();

    irq_clr = 1'b1;
    run_frame(0, 1, 1, 1, 2, 0, 0);
    irq_clr = 1'b0;
    repeat (2) @(negedge clk);
    chk(irq_flag == 1'b1, "R10 set wins over clear", irq_flag, 1);
    clear_flag();

    finish_run();
  end
endmodule